// File: doc/BRIEF.md
# Parity-Protected Asynchronous SRAM Controller

This block sits between a synchronous request port and an external asynchronous static RAM of 2^17 words by 9 bits. Each accepted request becomes one complete access on the memory pins. The block sets up the address, selects the device through a pair of enables of opposite polarity, and pulses either the read strobe or the write strobe for a number of clock cycles. It then lets the bus settle before it accepts the next request. The ninth memory bit holds parity: on a write the controller stores the parity bit, and on a read it recomputes parity and flags a mismatch.

All strobe and cycle lengths come from nanosecond parameters for the chosen speed grade. Each value is converted to clock cycles by rounding up against the clock period, with a floor of one cycle. The tri-state data bus appears as three signals: a drive value, a drive enable and the sampled bus. The pad is expected to be built from these three.

Top module: `sram_par_ctrl`

## Requirements
- R1: While reset is held and just after it, reqReady is 1, memCe1N is 1, memCe2 is 0, memOeN is 1, memWeN is 1 and memDqOe is 0.
- R2: The device is selected (memCe1N low and memCe2 high) whenever memOeN or memWeN is low. When no access is in progress it is deselected, and the strobes stay inactive.
- R3: A write holds memWeN low for exactly ceil(max(WE pulse, address-to-end-of-write, data setup) / clock period) cycles, 3 with defaults. memOeN stays high and memDqOe stays high the whole time.
- R4: The written word puts the 8 data bits on memDqOut[7:0] and even parity on memDqOut[8]: bit 8 is the XOR of bits 7:0, so the 9-bit word always has an even number of ones.
- R5: A read holds memOeN low for exactly ceil(max(address access, OE-to-valid) / clock period) cycles, 3 with defaults, with memWeN high. The bus is sampled at the end of the last such cycle. rspValid then pulses for one cycle with rspRdata equal to memDqIn[7:0].
- R6: rspParErr is 1 together with rspValid exactly when memDqIn[8] differs from the XOR of memDqIn[7:0] at the sample point. Otherwise it is 0.
- R7: From the cycle after a request is accepted, reqReady stays low for 1 setup cycle, plus the strobe cycles, plus max(1, cycle-time cycles − 1 − strobe cycles) recovery cycles. With defaults that is 5 cycles for both reads and writes.
- R8: A request is accepted only on a clock edge where reqReady is high. A reqValid held only while reqReady is low starts no access.
- R9: memDqOe is never high while memOeN is low, so the controller's bus driver and the memory's output driver are never on together.
- R10: memAddr equals the accepted request address for every cycle in which a strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 17 | Word address |
| reqWdata | input | 8 | Write data |
| reqReady | output | 1 | Controller can accept a request this edge |
| rspValid | output | 1 | One-cycle read-data strobe |
| rspRdata | output | 8 | Read data |
| rspParErr | output | 1 | Parity mismatch on the returned word |
| memAddr | output | 17 | Memory address pins |
| memCe1N | output | 1 | Active-low chip enable |
| memCe2 | output | 1 | Active-high chip enable |
| memOeN | output | 1 | Active-low output enable |
| memWeN | output | 1 | Active-low write enable |
| memDqOut | output | 9 | Value driven onto the data bus |
| memDqOe | output | 1 | Enable of the controller's bus driver |
| memDqIn | input | 9 | Sampled data bus |

## Verification
A wrong state or counter value inside the sequencer shows at the memory pins in the very next cycle. It appears as a write or read strobe one cycle too short or too long, or as the bus driver still on when the output enable falls. It also appears at the request port as reqReady returning early or late. A lost or stale parity bit shows only when that word is read back, where rspParErr rises in the rspValid cycle. The bench therefore measures strobe widths and busy time cycle by cycle against a behavioural memory, and it corrupts stored words to force the flag.

// File: rtl/sram_par_pkg.sv
package sram_par_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SETUP   = 2'd1,
    ST_STROBE  = 2'd2,
    ST_RECOVER = 2'd3
  } ctrlState_e;

  // Levels the memory pins take in the following cycle.
  typedef struct packed {
    logic select;
    logic readEn;
    logic writeEn;
    logic driveEn;
  } pinStrobe_t;

  // Everything the control hands to the datapath.
  typedef struct packed {
    pinStrobe_t pins;
    logic       load;
    logic       capture;
  } ctrlStrobe_t;

  function automatic int nsToCycles(input int ns, input int periodNs);
    int c;
    c = (ns + periodNs - 1) / periodNs;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int maxInt(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int recoverCycles(input int totalCyc, input int strobeCyc);
    return maxInt(1, totalCyc - 1 - strobeCyc);
  endfunction

endpackage

// File: rtl/sram_par_control.sv
module sram_par_control
  import sram_par_pkg::*;
#(
  parameter int RD_STROBE = 3,
  parameter int WR_STROBE = 3,
  parameter int RD_REC    = 1,
  parameter int WR_REC    = 1,
  parameter int CNT_W     = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  output logic        reqReady,
  output ctrlStrobe_t strobe
);

  ctrlState_e state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic opWrite, opNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      opWrite <= 1'b0;
    end else begin
      state   <= stateNext;
      cnt     <= cntNext;
      opWrite <= opNext;
    end
  end

  always_comb begin
    stateNext = state;
    cntNext   = cnt;
    opNext    = opWrite;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          stateNext = ST_SETUP;
          opNext    = reqWrite;
        end
      end
      ST_SETUP: begin
        stateNext = ST_STROBE;
        cntNext   = opWrite ? CNT_W'(WR_STROBE - 1) : CNT_W'(RD_STROBE - 1);
      end
      ST_STROBE: begin
        if (cnt == '0) begin
          stateNext = ST_RECOVER;
          cntNext   = opWrite ? CNT_W'(WR_REC - 1) : CNT_W'(RD_REC - 1);
        end else begin
          cntNext = cnt - 1'b1;
        end
      end
      ST_RECOVER: begin
        if (cnt == '0) stateNext = ST_IDLE;
        else           cntNext   = cnt - 1'b1;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign reqReady = (state == ST_IDLE);

  always_comb begin
    strobe.load         = reqValid && (state == ST_IDLE);
    strobe.capture      = (state == ST_STROBE) && !opWrite && (cnt == '0);
    strobe.pins.select  = (stateNext == ST_SETUP) || (stateNext == ST_STROBE);
    strobe.pins.readEn  = (stateNext == ST_STROBE) && !opNext;
    strobe.pins.writeEn = (stateNext == ST_STROBE) && opNext;
    strobe.pins.driveEn = opNext && ((stateNext == ST_SETUP) || (stateNext == ST_STROBE));
  end

  // R7: leaving the strobe always passes through recovery before idle
  assert_recover_after_strobe_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(state) == ST_STROBE && state != ST_STROBE) |-> (state == ST_RECOVER));

endmodule

// File: rtl/sram_par_datapath.sv
module sram_par_datapath
  import sram_par_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  localparam int WORD_W = DATA_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCe1N,
  output logic              memCe2,
  output logic              memOeN,
  output logic              memWeN,
  output logic [WORD_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [WORD_W-1:0] memDqIn,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  output logic              rspParErr
);

  pinStrobe_t pinReg;
  logic readMismatch;

  assign readMismatch = memDqIn[DATA_W] ^ (^memDqIn[DATA_W-1:0]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pinReg    <= '0;
      memAddr   <= '0;
      memDqOut  <= '0;
      rspValid  <= 1'b0;
      rspRdata  <= '0;
      rspParErr <= 1'b0;
    end else begin
      pinReg <= strobe.pins;
      if (strobe.load) begin
        memAddr  <= reqAddr;
        memDqOut <= {^reqWdata, reqWdata};
      end
      rspValid  <= strobe.capture;
      rspParErr <= strobe.capture && readMismatch;
      if (strobe.capture) rspRdata <= memDqIn[DATA_W-1:0];
    end
  end

  assign memCe1N = !pinReg.select;
  assign memCe2  = pinReg.select;
  assign memOeN  = !pinReg.readEn;
  assign memWeN  = !pinReg.writeEn;
  assign memDqOe = pinReg.driveEn;

  assert_no_contention_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(memDqOe && !memOeN));

  assert_oe_we_exclusive_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(!memOeN && !memWeN));

  assert_strobe_selected_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!memOeN || !memWeN) |-> (!memCe1N && memCe2));

  assert_write_data_held_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!memWeN && $past(!memWeN)) |-> ($stable(memDqOut) && memDqOe));

  assert_addr_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    (memCe2 && $past(memCe2)) |-> $stable(memAddr));

  assert_rsp_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  assert_err_with_data_R6: assert property (@(posedge clk) disable iff (!rstN)
    rspParErr |-> rspValid);

endmodule

// File: rtl/sram_par_ctrl.sv
module sram_par_ctrl
  import sram_par_pkg::*;
#(
  parameter int CLK_PERIOD_NS      = 20,
  parameter int T_ACCESS_NS        = 55,
  parameter int T_OE_VALID_NS      = 30,
  parameter int T_READ_CYCLE_NS    = 55,
  parameter int T_WE_PULSE_NS      = 40,
  parameter int T_ADDR_TO_WEEND_NS = 50,
  parameter int T_DATA_SETUP_NS    = 25,
  parameter int T_WRITE_CYCLE_NS   = 55,
  parameter int ADDR_W             = 17,
  parameter int DATA_W             = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqReady,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  output logic              rspParErr,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCe1N,
  output logic              memCe2,
  output logic              memOeN,
  output logic              memWeN,
  output logic [DATA_W:0]   memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W:0]   memDqIn
);

  localparam int RD_STROBE = nsToCycles(maxInt(T_ACCESS_NS, T_OE_VALID_NS), CLK_PERIOD_NS);
  localparam int WR_STROBE = nsToCycles(maxInt(T_WE_PULSE_NS,
                               maxInt(T_ADDR_TO_WEEND_NS, T_DATA_SETUP_NS)), CLK_PERIOD_NS);
  localparam int RD_REC    = recoverCycles(nsToCycles(T_READ_CYCLE_NS, CLK_PERIOD_NS), RD_STROBE);
  localparam int WR_REC    = recoverCycles(nsToCycles(T_WRITE_CYCLE_NS, CLK_PERIOD_NS), WR_STROBE);
  localparam int MAX_CNT   = maxInt(maxInt(RD_STROBE, WR_STROBE), maxInt(RD_REC, WR_REC));
  localparam int CNT_W     = $clog2(MAX_CNT + 1);

  ctrlStrobe_t strobe;

  sram_par_control #(
    .RD_STROBE(RD_STROBE), .WR_STROBE(WR_STROBE),
    .RD_REC(RD_REC), .WR_REC(WR_REC), .CNT_W(CNT_W)
  ) u_control (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .strobe(strobe)
  );

  sram_par_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqAddr(reqAddr), .reqWdata(reqWdata),
    .memAddr(memAddr), .memCe1N(memCe1N), .memCe2(memCe2),
    .memOeN(memOeN), .memWeN(memWeN),
    .memDqOut(memDqOut), .memDqOe(memDqOe), .memDqIn(memDqIn),
    .rspValid(rspValid), .rspRdata(rspRdata), .rspParErr(rspParErr)
  );

  // R8: no strobe starts without passing through an accepted request
  assert_start_needs_accept_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(memCe2)) |-> $past(reqReady && reqValid));

endmodule

// File: tb/sram_par_ctrl_test.sv
module sram_par_ctrl_test;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + 19) / 20;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int EXP_WE   = cyc(50);
  localparam int EXP_OE   = cyc(55);
  localparam int EXP_BUSY = 1 + 3 + ((cyc(55) - 4) > 1 ? (cyc(55) - 4) : 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [16:0] reqAddr = '0;
  logic [7:0] reqWdata = '0;
  logic reqReady, rspValid, rspParErr;
  logic [7:0] rspRdata;
  logic [16:0] memAddr;
  logic memCe1N, memCe2, memOeN, memWeN, memDqOe;
  logic [8:0] memDqOut, memDqIn;

  logic [8:0] mem [256];

  int checks = 0, errors = 0;
  int weLow, oeLow, addrBad, selBad, contention, rspSeen, cycles;
  logic [16:0] expAddr;
  logic [7:0] lastData;
  logic lastErr;

  always #10 clk = ~clk;

  sram_par_ctrl uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady),
    .rspValid(rspValid), .rspRdata(rspRdata), .rspParErr(rspParErr),
    .memAddr(memAddr), .memCe1N(memCe1N), .memCe2(memCe2),
    .memOeN(memOeN), .memWeN(memWeN), .memDqOut(memDqOut),
    .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  assign memDqIn = (!memCe1N && memCe2 && !memOeN && memWeN) ? mem[memAddr[7:0]] : 9'h1FF;

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog: act %0d cycles exp < 20000", cycles);
      summary();
    end
  end

  always @(negedge clk) begin
    if (!memWeN) weLow++;
    if (!memOeN) oeLow++;
    if ((!memWeN || !memOeN) && memAddr != expAddr) addrBad++;
    if ((!memWeN || !memOeN) && !(!memCe1N && memCe2)) selBad++;
    if (memDqOe && !memOeN) contention++;
    if (!memWeN && !memDqOe) contention++;
    if (!memWeN && !memCe1N && memCe2) mem[memAddr[7:0]] = memDqOut;
    if (rspValid) begin
      rspSeen++;
      lastData = rspRdata;
      lastErr = rspParErr;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: act %0h exp %0h", req, what, act, exp);
    end
  endtask

  task automatic clearCounts();
    weLow = 0; oeLow = 0; addrBad = 0; selBad = 0; rspSeen = 0;
  endtask

  int busy;
  task automatic doOp(input logic wr, input logic [16:0] a, input logic [7:0] d);
    @(negedge clk);
    clearCounts();
    expAddr = a;
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    busy = 0;
    while (!reqReady) begin
      busy++;
      @(negedge clk);
    end
  endtask

  // {write, addr[16:0], data[7:0], expErr}
  localparam logic [26:0] VEC [8] = '{
    {1'b1, 17'h00012, 8'hA7, 1'b0},
    {1'b1, 17'h1FF34, 8'h3C, 1'b0},
    {1'b1, 17'h0AB56, 8'h01, 1'b0},
    {1'b1, 17'h10078, 8'hFE, 1'b0},
    {1'b0, 17'h10078, 8'hFE, 1'b0},
    {1'b0, 17'h00012, 8'hA7, 1'b0},
    {1'b0, 17'h0AB56, 8'h01, 1'b0},
    {1'b0, 17'h1FF34, 8'h3C, 1'b0}
  };

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    contention = 0; cycles = 0; expAddr = '0;
    clearCounts();
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(reqReady == 1'b1, "R1", "ready in reset", reqReady, 1);
    chk(memCe1N == 1'b1 && memCe2 == 1'b0, "R1", "deselected in reset", {memCe1N, memCe2}, 2'b10);
    chk(memOeN && memWeN && !memDqOe, "R1", "strobes idle in reset", {memOeN, memWeN, memDqOe}, 3'b110);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(reqReady && memCe1N && !memCe2 && memOeN && memWeN && !memDqOe, "R1", "idle after reset",
        {reqReady, memCe1N, memCe2, memOeN, memWeN, memDqOe}, 6'b111110);

    for (int v = 0; v < 8; v++) begin
      logic wr; logic [16:0] a; logic [7:0] d; logic e;
      {wr, a, d, e} = VEC[v];
      doOp(wr, a, d);
      chk(busy == EXP_BUSY, "R7", "busy cycles", busy, EXP_BUSY);
      chk(addrBad == 0, "R10", "address during strobe", addrBad, 0);
      chk(selBad == 0, "R2", "select during strobe", selBad, 0);
      if (wr) begin
        chk(weLow == EXP_WE, "R3", "WE low cycles", weLow, EXP_WE);
        chk(oeLow == 0, "R3", "OE during write", oeLow, 0);
        chk(mem[a[7:0]] == {^d, d}, "R4", "stored word with parity", mem[a[7:0]], {^d, d});
      end else begin
        chk(oeLow == EXP_OE, "R5", "OE low cycles", oeLow, EXP_OE);
        chk(weLow == 0, "R5", "WE during read", weLow, 0);
        chk(rspSeen == 1, "R5", "one response pulse", rspSeen, 1);
        chk(lastData == d, "R5", "read data", lastData, d);
        chk(lastErr == e, "R6", "parity flag clean", lastErr, e);
      end
    end

    // R6: corrupt parity bit, then a data bit
    mem[8'h34] = mem[8'h34] ^ 9'h100;
    doOp(1'b0, 17'h1FF34, 8'h00);
    chk(rspSeen == 1 && lastErr == 1'b1, "R6", "flag on bad parity bit", lastErr, 1);
    chk(lastData == 8'h3C, "R6", "data with bad parity", lastData, 8'h3C);
    mem[8'h12] = mem[8'h12] ^ 9'h001;
    doOp(1'b0, 17'h00012, 8'h00);
    chk(lastErr == 1'b1 && lastData == 8'hA6, "R6", "flag on flipped data bit", {lastErr, lastData}, 9'h1A6);
    doOp(1'b0, 17'h10078, 8'h00);
    chk(lastErr == 1'b0, "R6", "flag clears on good word", lastErr, 0);

    // R8: request present only while busy is not taken
    @(negedge clk);
    expAddr = 17'h00056;
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = 17'h0AB56;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqWrite = 1'b1; reqAddr = 17'h00099; reqWdata = 8'h55;
    while (!reqReady) @(negedge clk);
    reqValid = 1'b0;
    clearCounts();
    repeat (8) @(negedge clk);
    chk(weLow == 0 && oeLow == 0, "R8", "no access after busy-only request", weLow + oeLow, 0);
    chk(mem[8'h99] == 9'h000, "R8", "location untouched", mem[8'h99], 0);
    chk(memCe1N && !memCe2, "R2", "deselected when idle", {memCe1N, memCe2}, 2'b10);

    // R9: write immediately followed by read
    doOp(1'b1, 17'h000AA, 8'h5A);
    doOp(1'b0, 17'h000AA, 8'h00);
    chk(lastData == 8'h5A && !lastErr, "R5", "read after write", lastData, 8'h5A);
    chk(contention == 0, "R9", "driver overlap events", contention, 0);

    summary();
  end

endmodule